// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of 32 general-purpose pins behind a small synchronous register port. Each pin works in one of two modes. In I/O mode it is a plain input or a driven output. In interrupt mode its pad driver is off and the pin feeds a detector. The detector can sense a level (high or low) or an edge (rising, falling, or both).

Every pin input passes through a two-flop synchronizer. An optional per-pin glitch filter follows the synchronizer. Edge detection then updates a per-pin status bit, which software clears by writing ones. A per-pin enable bit selects which status bits reach the single combined interrupt request. Two write-only-effect registers change the enables: one clears enable bits and the other sets them. Software therefore never needs a read-modify-write to change one enable.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration register, every status bit and every enable bit is 0. `irq`, `pin_oe` and `pin_out` are all 0.
- R2: Bit i of each register belongs to pin i. The following registers read back the last value written: offset 0x00 mode (1 = interrupt input, 0 = I/O), 0x04 direction (1 = output), 0x08 output data, 0x20 polarity, 0x24 sense (1 = edge, 0 = level), 0x28 filter enable and 0x4C both-edge. Reads of any unlisted offset return 0.
- R3: `pin_out` equals the output data register. `pin_oe` is the direction bit AND NOT the mode bit, so a pin in interrupt mode is never driven.
- R4: Offset 0x0C reads the pin inputs as seen through a two-flop synchronizer. A change on `pin_in` becomes visible after two clock edges.
- R5: In level mode the status bit follows the pin level live: active when the pin is high with polarity 0, or low with polarity 1. Writes to the clear register do not affect it.
- R6: In edge mode with both-edge 0, polarity 0 latches status on a rising input and polarity 1 latches it on a falling input. The bit stays set until it is cleared. `irq` rises three clock edges after the pin change.
- R7: In edge mode, a both-edge bit of 1 latches status on either transition, whatever the polarity bit holds.
- R8: Writing 1 to a bit of offset 0x14 clears that edge status bit, and writing 0 has no effect. If a new edge and a clear of the same bit occur in the same cycle, the bit stays set.
- R9: The enable bits read at offset 0x18. A write to 0x18 clears each enable bit written as 0 and leaves the others unchanged. A write of 1 to a bit of 0x1C sets that enable bit. Offsets 0x14 and 0x1C read as 0.
- R10: `irq` is high exactly when some status bit and its enable bit are both 1. A status bit set while its enable is 0 raises `irq` once the bit is enabled. A pin in I/O mode has status 0.
- R11: With the filter bit set, a new input level is accepted only after four consecutive clocks at that level. A pulse of three clocks is ignored, and a held level reaches the status bit four clocks later than it would unfiltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pad |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, so the bench reads it back at the following falling edge. A pin change reaches input readback two edges later and reaches status and `irq` three edges later; with the filter on, status and `irq` follow seven edges later. Enable changes act on `irq` in the same cycle the enable register updates. Each task drives the pins at a falling edge, counts exactly that many rising edges, and samples at the next falling edge. It also samples one edge early where the latency itself is the point under test. The clear/edge collision is staged so that the clear strobe lands on the third edge.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS    = 32,
  parameter int FILT_LEN = 4,
  parameter int AW       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CMAX = CW'(FILT_LEN - 1);
  localparam logic [AW-1:0] A_MODE = AW'('h00), A_DIR = AW'('h04), A_DOUT = AW'('h08),
                            A_DIN  = AW'('h0C), A_STAT = AW'('h10), A_CLR = AW'('h14),
                            A_MASK = AW'('h18), A_UNMASK = AW'('h1C), A_POL = AW'('h20),
                            A_SENSE = AW'('h24), A_FILT = AW'('h28), A_BOTH = AW'('h4C);

  logic [NPINS-1:0] mode_q, dir_q, dout_q, pol_q, sense_q, filt_q, both_q, ena_q, stat_q;
  logic [NPINS-1:0] s1_q, s2_q, flt_q, lvl_d_q;
  logic [NPINS-1:0] lvl, rise, fall, hit, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; dir_q <= '0; dout_q <= '0; pol_q <= '0;
      sense_q <= '0; filt_q <= '0; both_q <= '0; ena_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE:   mode_q  <= bus_wdata;
        A_DIR:    dir_q   <= bus_wdata;
        A_DOUT:   dout_q  <= bus_wdata;
        A_POL:    pol_q   <= bus_wdata;
        A_SENSE:  sense_q <= bus_wdata;
        A_FILT:   filt_q  <= bus_wdata;
        A_BOTH:   both_q  <= bus_wdata;
        A_MASK:   ena_q   <= ena_q & bus_wdata;
        A_UNMASK: ena_q   <= ena_q | bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0;
    end else begin
      s1_q <= pin_in; s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_filt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0; flt_q[i] <= 1'b0;
      end else if (!filt_q[i] || s2_q[i] == flt_q[i]) begin
        cnt_q <= '0; flt_q[i] <= s2_q[i];
      end else if (cnt_q == CMAX) begin
        cnt_q <= '0; flt_q[i] <= s2_q[i];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl  = (filt_q & flt_q) | (~filt_q & s2_q);
  assign rise = lvl & ~lvl_d_q;
  assign fall = ~lvl & lvl_d_q;
  assign hit  = mode_q & sense_q &
                ((both_q & (rise | fall)) | (~both_q & ~pol_q & rise) | (~both_q & pol_q & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d_q <= '0; stat_q <= '0;
    end else begin
      lvl_d_q <= lvl;
      stat_q  <= (mode_q & ~sense_q & (lvl ^ pol_q)) |
                 (mode_q & sense_q & ((stat_q & ~clr) | hit));
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_DIR:   bus_rdata = dir_q;
      A_DOUT:  bus_rdata = dout_q;
      A_DIN:   bus_rdata = s2_q;
      A_STAT:  bus_rdata = stat_q;
      A_MASK:  bus_rdata = ena_q;
      A_POL:   bus_rdata = pol_q;
      A_SENSE: bus_rdata = sense_q;
      A_FILT:  bus_rdata = filt_q;
      A_BOTH:  bus_rdata = both_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq     = |(stat_q & ena_q);

  // R6
  sticky_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((stat_q & $past(stat_q & mode_q & sense_q)) == $past(stat_q & mode_q & sense_q)));
  // R9
  mask_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MASK) |=> ((ena_q & ~$past(ena_q)) == '0));
  // R9
  unmask_only_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_UNMASK) |=> (($past(ena_q) & ~ena_q) == '0));
  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ena_q != '0));
  // R8
  clear_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR && !bus_we_mode_sense()) |=>
      ((stat_q & $past(bus_wdata & mode_q & sense_q & ~hit)) == '0));

  function automatic logic bus_we_mode_sense();
    return 1'b0;
  endfunction
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  gpio_irq_bank u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  always #4 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cfg_clear();
    wr(7'h00, 0); wr(7'h04, 0); wr(7'h08, 0); wr(7'h20, 0); wr(7'h24, 0);
    wr(7'h28, 0); wr(7'h4C, 0); wr(7'h18, 0); wr(7'h14, '1);
    pin_in = '0; tick(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (d[i]) ;
    for (int a = 0; a < 'h50; a += 4) begin
      rd(7'(a), d);
      chk($sformatf("R1 reg %02h", a), d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(7'h04, 32'hFFFF_0000); wr(7'h08, 32'hA5A5_0F0F); wr(7'h00, 32'h0F0F_0F0F);
    wr(7'h20, 32'h1234_5678); wr(7'h24, 32'h8765_4321); wr(7'h28, 32'hDEAD_BEEF);
    wr(7'h4C, 32'hCAFE_F00D);
    rd(7'h04, d); chk("R2 dir", d, 32'hFFFF_0000);
    rd(7'h08, d); chk("R2 dout", d, 32'hA5A5_0F0F);
    rd(7'h00, d); chk("R2 mode", d, 32'h0F0F_0F0F);
    rd(7'h20, d); chk("R2 pol", d, 32'h1234_5678);
    rd(7'h24, d); chk("R2 sense", d, 32'h8765_4321);
    rd(7'h28, d); chk("R2 filt", d, 32'hDEAD_BEEF);
    rd(7'h4C, d); chk("R2 both", d, 32'hCAFE_F00D);
    rd(7'h30, d); chk("R2 unlisted", d, 0);
    chk("R3 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R3 pin_oe", pin_oe, 32'hF0F0_0000);
    cfg_clear();
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pin_in = 32'h1234_5678;
    tick(1); rd(7'h0C, d); chk("R4 one edge", d, 0);
    tick(1); rd(7'h0C, d); chk("R4 two edges", d, 32'h1234_5678);
    cfg_clear();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(7'h00, 32'h8); wr(7'h1C, 32'h8);
    chk("R5 idle irq", {31'b0, irq}, 0);
    pin_in[3] = 1;
    tick(2); chk("R5 early irq", {31'b0, irq}, 0);
    tick(1); chk("R5 high irq", {31'b0, irq}, 1);
    wr(7'h14, 32'h8);
    rd(7'h10, d); chk("R5 clear ignored", d, 32'h8);
    pin_in[3] = 0;
    tick(3); chk("R5 follows low", {31'b0, irq}, 0);
    wr(7'h20, 32'h8);
    tick(1); chk("R5 active low", {31'b0, irq}, 1);
    cfg_clear();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(7'h00, 32'h80); wr(7'h24, 32'h80); wr(7'h1C, 32'h80); wr(7'h14, '1);
    pin_in[7] = 1;
    tick(2); chk("R6 early", {31'b0, irq}, 0);
    tick(1); chk("R6 rising", {31'b0, irq}, 1);
    pin_in[7] = 0;
    tick(3); chk("R6 sticky", {31'b0, irq}, 1);
    wr(7'h14, 0); chk("R8 zero write", {31'b0, irq}, 1);
    wr(7'h14, 32'h80); chk("R8 one clears", {31'b0, irq}, 0);
    wr(7'h20, 32'h80);
    pin_in[7] = 1;
    tick(3); chk("R6 falling ignores rise", {31'b0, irq}, 0);
    pin_in[7] = 0;
    tick(3); chk("R6 falling", {31'b0, irq}, 1);
    wr(7'h14, 32'h80); wr(7'h20, 0);
    pin_in[7] = 1;
    tick(2); wr(7'h14, 32'h80);
    rd(7'h10, d); chk("R8 edge wins", d, 32'h80);
    wr(7'h14, 32'h80);
    rd(7'h10, d); chk("R8 cleared", d, 0);
    cfg_clear();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(7'h00, 32'h200); wr(7'h24, 32'h200); wr(7'h4C, 32'h200); wr(7'h20, 32'h200);
    wr(7'h1C, 32'h200); wr(7'h14, '1);
    pin_in[9] = 1;
    tick(3); rd(7'h10, d); chk("R7 rise", d, 32'h200);
    wr(7'h14, 32'h200);
    rd(7'h10, d); chk("R7 cleared", d, 0);
    pin_in[9] = 0;
    tick(3); rd(7'h10, d); chk("R7 fall", d, 32'h200);
    cfg_clear();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(7'h1C, 32'hF0F0_00FF);
    rd(7'h18, d); chk("R9 set", d, 32'hF0F0_00FF);
    wr(7'h18, 32'h0FFF_FF0F);
    rd(7'h18, d); chk("R9 clear", d, 32'h00F0_000F);
    rd(7'h1C, d); chk("R9 1C reads 0", d, 0);
    rd(7'h14, d); chk("R9 14 reads 0", d, 0);
    wr(7'h18, 0);
    wr(7'h00, 32'h80); wr(7'h24, 32'h80); wr(7'h14, '1);
    pin_in[7] = 1; pin_in[2] = 1;
    tick(3); chk("R10 disabled", {31'b0, irq}, 0);
    rd(7'h10, d); chk("R10 status, io pin 0", d, 32'h80);
    wr(7'h1C, 32'h80); chk("R10 enabled", {31'b0, irq}, 1);
    cfg_clear();
  endtask

  task automatic t_filter();
    logic [31:0] d;
    wr(7'h00, 32'h20); wr(7'h24, 32'h20); wr(7'h28, 32'h20); wr(7'h1C, 32'h20);
    wr(7'h14, '1);
    pin_in[5] = 1; tick(3); pin_in[5] = 0;
    tick(8); chk("R11 short pulse", {31'b0, irq}, 0);
    rd(7'h10, d); chk("R11 short status", d, 0);
    pin_in[5] = 1;
    tick(6); chk("R11 early", {31'b0, irq}, 0);
    tick(1); chk("R11 accepted", {31'b0, irq}, 1);
    cfg_clear();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_regs();
    t_sync();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_filter();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule